// File: doc/BRIEF.md
# Processor Reset and Clock-Enable Sequencer

This block sits inside a system controller that serves a microcontroller (MCU) and a signal processor (DSP). It takes the board's active-low power-up reset and turns it into a staged bring-up. The fast clock enable comes up first. The MCU clock then runs while the MCU is still held in reset, because both processors reset synchronously and need clock edges to do so. The MCU reset is released after a fixed count of MCU clock edges. The DSP and peripheral resets stay asserted until MCU software clears a control bit. The same software can assert them again at any time.

The slow sleep-clock enable is also a software bit and stays off after power-up. Output enables for bidirectional pins shared with each processor are forced low, so those pins act as inputs, while that processor is in reset. Everything runs on one clock. The MCU clock is a divided enable pulse, and the DSP domain uses the full-rate enable.

Top module: `mp_reset_seq`

## Requirements
- R1: While `por_n` is low, all reset outputs, all clock enables and all pin output enables are low, immediately and without any clock edge.
- R2: After `por_n` goes high, `dsp_clk_en` goes high after the second rising clock edge and stays high until `por_n` falls again.
- R3: `mcu_clk_en` is high for one cycle in every `MCU_DIV` cycles while `dsp_clk_en` is high. Its first pulse is in the same cycle that `dsp_clk_en` first goes high, and it runs while `mcu_rst_n` is still low.
- R4: `mcu_rst_n` goes high at the `MCU_RST_CYCLES`-th rising edge taken while `mcu_clk_en` is high. Counting clock edges from the release of `por_n`, that is after edge 3+(`MCU_RST_CYCLES`-1)*`MCU_DIV`. It then stays high until `por_n` falls.
- R5: The control register sits at address `CTRL_ADDR`. Bit 0 is the DSP hold and resets to 1. Bit 1 is the slow-clock enable and resets to 0. A write (`wr_en`=1 and a matching address) updates both bits at the clock edge.
- R6: A write is ignored if `mcu_rst_n` is low or if the address differs from `CTRL_ADDR`.
- R7: `dsp_rst_n` goes high after the second clock edge following the edge that stored hold=0. Storing hold=1 drives it low right after that edge. It never goes high while `mcu_rst_n` is low.
- R8: `periph_rst_n` equals `dsp_rst_n`, and it also falls combinationally with `por_n`.
- R9: `slow_clk_en` equals the stored bit 1.
- R10: `mcu_oe` equals `mcu_oe_req` while `mcu_rst_n` is high and is all zero otherwise. `dsp_oe` relates to `dsp_oe_req` and `dsp_rst_n` in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| por_n | input | 1 | External power-up reset, active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data (bit 0 DSP hold, bit 1 slow-clock enable) |
| mcu_oe_req | input | MCU_PINS | Requested output enables of MCU-shared pins |
| dsp_oe_req | input | DSP_PINS | Requested output enables of DSP-shared pins |
| dsp_clk_en | output | 1 | Full-rate clock enable for the DSP domain |
| mcu_clk_en | output | 1 | Divided clock enable for the MCU domain |
| slow_clk_en | output | 1 | Sleep-clock enable |
| mcu_rst_n | output | 1 | MCU reset, active low |
| dsp_rst_n | output | 1 | DSP reset, active low |
| periph_rst_n | output | 1 | Peripheral reset, active low, asynchronous assert |
| mcu_oe | output | MCU_PINS | Gated output enables of MCU-shared pins |
| dsp_oe | output | DSP_PINS | Gated output enables of DSP-shared pins |

## Verification
The result timings are as follows:
- The clock enables appear two edges after the reset is released.
- The MCU release follows edge 3+(`MCU_RST_CYCLES`-1)*`MCU_DIV`.
- A stored register bit is visible right after its write edge.
- The DSP release trails the edge that stored hold=0 by two more edges.
- Pin gating and reset assertion by `por_n` follow with no edge at all.

The bench model counts edges since release and tracks the register and release delay as plain integers. Inputs change 2 ns after a rising edge, and every output is compared on the falling edge, once all of these delays have settled. The combinational assertion by `por_n` is checked 1 ns after it falls, before any edge.

// File: rtl/mp_reset_seq.sv
module mp_reset_seq #(
  parameter int MCU_DIV        = 2,
  parameter int MCU_RST_CYCLES = 128,
  parameter int ADDR_W         = 4,
  parameter int DATA_W         = 8,
  parameter int CTRL_ADDR      = 0,
  parameter int MCU_PINS       = 8,
  parameter int DSP_PINS       = 4
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [MCU_PINS-1:0] mcu_oe_req,
  input  logic [DSP_PINS-1:0] dsp_oe_req,
  output logic                dsp_clk_en,
  output logic                mcu_clk_en,
  output logic                slow_clk_en,
  output logic                mcu_rst_n,
  output logic                dsp_rst_n,
  output logic                periph_rst_n,
  output logic [MCU_PINS-1:0] mcu_oe,
  output logic [DSP_PINS-1:0] dsp_oe
);

  localparam int DIV_W = (MCU_DIV > 1) ? $clog2(MCU_DIV) : 1;
  localparam int CNT_W = $clog2(MCU_RST_CYCLES + 1);

  logic [1:0]       por_sync;
  logic             run;
  logic [DIV_W-1:0] div;
  logic [CNT_W-1:0] edge_cnt;
  logic             mcu_out_q;
  logic             hold_q;
  logic             slow_q;
  logic [1:0]       dsp_stage;
  logic             wr_hit;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) por_sync <= 2'b00;
    else        por_sync <= {por_sync[0], 1'b1};

  assign run = por_sync[1];

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)                              div <= '0;
    else if (!run)                           div <= '0;
    else if (div == DIV_W'(MCU_DIV - 1))     div <= '0;
    else                                     div <= div + 1'b1;

  assign dsp_clk_en = run;
  assign mcu_clk_en = run && (div == '0);

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      edge_cnt  <= '0;
      mcu_out_q <= 1'b0;
    end else if (mcu_clk_en && !mcu_out_q) begin
      edge_cnt <= edge_cnt + 1'b1;
      if (edge_cnt == CNT_W'(MCU_RST_CYCLES - 1)) mcu_out_q <= 1'b1;
    end

  assign wr_hit = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR)) && mcu_out_q;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      hold_q <= 1'b1;
      slow_q <= 1'b0;
    end else if (wr_hit) begin
      hold_q <= wr_data[0];
      slow_q <= wr_data[1];
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)      dsp_stage <= 2'b00;
    else if (hold_q) dsp_stage <= 2'b00;
    else             dsp_stage <= {dsp_stage[0], 1'b1};

  assign mcu_rst_n    = mcu_out_q;
  assign dsp_rst_n    = dsp_stage[1] && !hold_q;
  assign periph_rst_n = por_n && dsp_rst_n;
  assign slow_clk_en  = slow_q;
  assign mcu_oe       = mcu_rst_n ? mcu_oe_req : '0;
  assign dsp_oe       = dsp_rst_n ? dsp_oe_req : '0;

  a_r1_no_release_before_clock: assert property (@(posedge clk) disable iff (!por_n)
    !dsp_clk_en |-> (!mcu_rst_n && !dsp_rst_n));
  a_r4_release_on_mcu_edge: assert property (@(posedge clk) disable iff (!por_n)
    $rose(mcu_rst_n) |-> $past(mcu_clk_en));
  a_r4_mcu_release_sticky: assert property (@(posedge clk) disable iff (!por_n)
    mcu_rst_n |=> mcu_rst_n);
  a_r7_dsp_after_mcu: assert property (@(posedge clk) disable iff (!por_n)
    dsp_rst_n |-> mcu_rst_n);
  a_r7_release_needs_clear: assert property (@(posedge clk) disable iff (!por_n)
    $rose(dsp_rst_n) |-> !$past(hold_q));
  a_r9_slow_needs_mcu: assert property (@(posedge clk) disable iff (!por_n)
    slow_clk_en |-> mcu_rst_n);

endmodule

// File: tb/mp_reset_seq_tb.sv
module mp_reset_seq_tb_top;
  localparam int DIV = 2, NRST = 128, AW = 4, DW = 8, CTRL = 0, MP = 8, DP = 4;
  localparam int REL = 3 + (NRST - 1) * DIV;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic por_n, wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [MP-1:0] mcu_oe_req, mcu_oe;
  logic [DP-1:0] dsp_oe_req, dsp_oe;
  logic dsp_clk_en, mcu_clk_en, slow_clk_en, mcu_rst_n, dsp_rst_n, periph_rst_n;

  mp_reset_seq #(.MCU_DIV(DIV), .MCU_RST_CYCLES(NRST), .ADDR_W(AW), .DATA_W(DW),
                 .CTRL_ADDR(CTRL), .MCU_PINS(MP), .DSP_PINS(DP)) dut_i (
    .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mcu_oe_req(mcu_oe_req), .dsp_oe_req(dsp_oe_req), .dsp_clk_en(dsp_clk_en),
    .mcu_clk_en(mcu_clk_en), .slow_clk_en(slow_clk_en), .mcu_rst_n(mcu_rst_n),
    .dsp_rst_n(dsp_rst_n), .periph_rst_n(periph_rst_n), .mcu_oe(mcu_oe), .dsp_oe(dsp_oe));

  int n_cmp = 0, n_bad = 0;
  int k = 0, z = 0;
  bit hold_m = 1'b1, slow_m = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: edges since release, register contents, release delay
  always @(posedge clk) begin
    bit was_out, acc;
    if (!por_n) begin
      k = 0; z = 0; hold_m = 1'b1; slow_m = 1'b0;
    end else begin
      was_out = (k >= REL);
      acc = wr_en && (wr_addr == AW'(CTRL)) && was_out;
      z = hold_m ? 0 : ((z < 10) ? z + 1 : z);
      if (acc) begin
        hold_m = wr_data[0];
        slow_m = wr_data[1];
      end
      k++;
    end
  end

  always @(negedge clk) begin
    bit e_run, e_men, e_mcu, e_dsp;
    if (!por_n) begin
      chk("R1 dsp_clk_en", dsp_clk_en, 0);
      chk("R1 mcu_clk_en", mcu_clk_en, 0);
      chk("R1 resets", {mcu_rst_n, dsp_rst_n, periph_rst_n}, 0);
      chk("R1 pin enables", {mcu_oe, dsp_oe}, 0);
    end else begin
      e_run = (k >= 2);
      e_men = e_run && (((k - 2) % DIV) == 0);
      e_mcu = (k >= REL);
      e_dsp = e_mcu && !hold_m && (z >= 2);
      chk("R2 dsp_clk_en", dsp_clk_en, e_run);
      chk("R3 mcu_clk_en", mcu_clk_en, e_men);
      chk("R4 mcu_rst_n", mcu_rst_n, e_mcu);
      chk("R7 dsp_rst_n", dsp_rst_n, e_dsp);
      chk("R8 periph_rst_n", periph_rst_n, e_dsp);
      chk("R9 slow_clk_en", slow_clk_en, slow_m);
      chk("R10 mcu_oe", mcu_oe, e_mcu ? mcu_oe_req : '0);
      chk("R10 dsp_oe", dsp_oe, e_dsp ? dsp_oe_req : '0);
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    por_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    mcu_oe_req = '1; dsp_oe_req = '1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 reset state", {mcu_rst_n, dsp_rst_n, dsp_clk_en, slow_clk_en}, 0);
    @(posedge clk); #2 por_n = 1'b1;
    repeat (20) @(posedge clk);
    mcu_oe_req = 8'hA5;
    // R6: write during MCU reset is ignored
    wr(AW'(CTRL), 8'h02);
    @(negedge clk);
    chk("R6 write in MCU reset ignored", {slow_clk_en, dsp_rst_n}, 0);
    repeat (REL) @(posedge clk);
    @(negedge clk);
    chk("R4 MCU released", mcu_rst_n, 1);
    chk("R10 mcu_oe pass", mcu_oe, 8'hA5);
    // R6: wrong address ignored
    wr(AW'(CTRL + 1), 8'h02);
    @(negedge clk);
    chk("R6 wrong address ignored", {slow_clk_en, dsp_rst_n}, 0);
    // R5 / R9: slow clock on, hold kept
    wr(AW'(CTRL), 8'h03);
    @(negedge clk);
    chk("R9 slow on", slow_clk_en, 1);
    chk("R5 hold kept", dsp_rst_n, 0);
    repeat (4) @(posedge clk);
    dsp_oe_req = 4'h9;
    // R7: release DSP
    wr(AW'(CTRL), 8'h02);
    @(negedge clk);
    chk("R7 not yet released", dsp_rst_n, 0);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R7 released", dsp_rst_n, 1);
    chk("R8 periph released", periph_rst_n, 1);
    chk("R10 dsp_oe pass", dsp_oe, 4'h9);
    repeat (5) @(posedge clk);
    // R7: reassert by software
    wr(AW'(CTRL), 8'h01);
    @(negedge clk);
    chk("R7 reasserted", {dsp_rst_n, periph_rst_n}, 0);
    chk("R10 dsp_oe forced", dsp_oe, 0);
    chk("R9 slow off", slow_clk_en, 0);
    repeat (5) @(posedge clk);
    wr(AW'(CTRL), 8'h00);
    repeat (6) @(posedge clk);
    // R1 / R8: asynchronous assertion
    @(posedge clk); #2 por_n = 1'b0;
    #1;
    chk("R1 async resets", {mcu_rst_n, dsp_rst_n, dsp_clk_en, mcu_clk_en}, 0);
    chk("R8 periph async", periph_rst_n, 0);
    chk("R10 oe async", {mcu_oe, dsp_oe}, 0);
    repeat (3) @(posedge clk);
    #2 por_n = 1'b1;
    repeat (REL + 5) @(posedge clk);
    @(negedge clk);
    chk("R4 MCU released again", mcu_rst_n, 1);
    chk("R5 hold back to 1", dsp_rst_n, 0);
    chk("R5 slow back to 0", slow_clk_en, 0);
    finish_run();
  end
endmodule